// File: doc/BRIEF.md
# Host-Port Request and Vector Logic

This block holds the host-facing request and status logic of an 8-bit parallel host port on a signal processor. It tracks two handshake flags: one says the transmit data register is empty and the other says the receive data register is full. Each flag has a host enable mask. In the non-DMA mode, the block combines each flag with its mask into an active-low request line. The line is modelled as an open-drain output, so several ports can share one wire. While the request line and the host acknowledge are both active, the block places its vector register on the host data bus. This lets the host select a service routine without a separate read.

The host works through a small register bus, with an address, a read strobe, a write strobe and 8-bit data. It sees a control register, a command register, a read-only status register, the vector register and the data register. The processor core uses one-cycle strobes: one loads received bytes, one takes transmitted bytes and one accepts a pending host command.

Top module: `hpi_irq_top`

## Requirements
- R1: After reset the request line is released (output enable 0) and the bus is not driven. Reads then return 0x00 from control, 0x0F from vector and 0x02 from status (transmit-empty 1, receive-full 0).
- R2: Register addresses: 0 control, 1 command, 2 status, 3 vector, 4 data. Control and vector read back what was written, and only the low 4 bits of control are kept. Writes to status are ignored, and the unused addresses 5–7 read 0x00.
- R3: Control bit 0 enables the transmit request, bit 1 enables the receive request, and bits 3:2 select the host mode. With mode 00, the request output enable is 1 in the cycle after (transmit-empty AND bit 0) OR (receive-full AND bit 1) becomes true.
- R4: The request is released in the cycle after its condition ends, whether the host services the data register or clears the mask.
- R5: A core load strobe stores the received byte and sets receive-full. A host read of address 4 returns that byte and clears receive-full. If a load and a read fall in the same cycle, the read returns the old byte and receive-full stays set.
- R6: A host write of address 4 stores the transmit byte, presents it to the core and clears transmit-empty. A core take strobe sets transmit-empty. If the two fall in the same cycle, transmit-empty stays set.
- R7: While the request output enable and the acknowledge input are both 1, the bus drive enable is 1 and the bus carries the vector register in that same cycle. This takes priority over pending read data. An acknowledge with no request drives nothing.
- R8: A write to address 1 stores bit 7 as the command-pending bit and bits 4:0 as the command vector. Reads return {pending, 2'b00, vector}. While the command is pending, further writes are ignored. A core accept strobe clears the pending bit in the next cycle.
- R9: Status bit 7 mirrors the request output enable, and bit 6 reads 1 when either mode bit is nonzero. Bit 1 is transmit-empty and bit 0 is receive-full. With a nonzero mode the request output enable stays 0.
- R10: Read data and its drive enable appear in the cycle after the read strobe and last exactly one cycle. Without a read or a vector condition, the drive enable is 0.
- R11: The request data output is constant 0, so the line is only ever pulled low or released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 3 | Host register address |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_ack | input | 1 | Host acknowledge (active high) |
| host_rdata | output | 8 | Host bus data out |
| host_rdata_oe | output | 1 | Host bus drive enable |
| irq_o | output | 1 | Request line data value (always 0) |
| irq_oe | output | 1 | Request line drive enable (1 pulls the line low) |
| core_rx_load | input | 1 | Core strobe: received byte is valid |
| core_rx_data | input | 8 | Received byte from the core |
| core_tx_take | input | 1 | Core strobe: transmit byte taken |
| core_tx_data | output | 8 | Transmit byte for the core |
| core_cmd_accept | input | 1 | Core accepts the pending command |
| core_cmd_pend | output | 1 | Host command pending |
| core_cmd_vec | output | 5 | Host command vector |

## Verification
The bench aims at the same-cycle collisions on the flags. If a load arrives with a read, or a take with a write, a design that lets the clear win would lose a byte or stall the request. It drives the acknowledge together with a pending read, and a design with the wrong bus priority would put stale register data where the vector belongs. It writes the command register while a command is pending, and a design without the guard would overwrite the vector the core is about to take. It also switches the mode bits while a request is active, and a design without the mode gate would keep pulling the shared line low in DMA mode.

// File: rtl/hpi_pkg.sv
// Package: shared constants and types for the host-port request logic.
// Assumes an 8-bit host data path and a 3-bit register address.
package hpi_pkg;

    localparam int HPI_ADDR_W = 3;

    localparam logic [HPI_ADDR_W-1:0] ADR_CTRL = 3'd0;
    localparam logic [HPI_ADDR_W-1:0] ADR_CMD  = 3'd1;
    localparam logic [HPI_ADDR_W-1:0] ADR_STAT = 3'd2;
    localparam logic [HPI_ADDR_W-1:0] ADR_VEC  = 3'd3;
    localparam logic [HPI_ADDR_W-1:0] ADR_DATA = 3'd4;

    // Status bit positions decoded by the host software
    localparam int ST_RXF = 0;
    localparam int ST_TXE = 1;
    localparam int ST_DMA = 6;
    localparam int ST_REQ = 7;

    // Control register layout: [3:2] mode, [1] rx enable, [0] tx enable
    typedef struct packed {
        logic [1:0] mode;
        logic       rx_en;
        logic       tx_en;
    } hpi_ctrl_t;

    localparam int CTRL_W = $bits(hpi_ctrl_t);

endpackage

// File: rtl/hpi_flags.sv
// Module: data-register handshake flags.
// Holds the receive byte with its full flag and the transmit byte with its
// empty flag. Core set strobes take priority over host clears.
// Assumes strobes are one cycle wide.
module hpi_flags #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_rd_data,
    input  logic              host_wr_data,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rx_load,
    input  logic [DATA_W-1:0] rx_din,
    input  logic              tx_take,
    output logic              rx_full,
    output logic              tx_empty,
    output logic [DATA_W-1:0] rx_q,
    output logic [DATA_W-1:0] tx_q
);

    // Receive byte and full flag; a core load beats a host read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_full <= 1'b0;
            rx_q    <= '0;
        end else if (rx_load) begin
            rx_full <= 1'b1;
            rx_q    <= rx_din;
        end else if (host_rd_data) begin
            rx_full <= 1'b0;
        end
    end

    // Transmit byte storage, written by the host
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_q <= '0;
        else if (host_wr_data)
            tx_q <= wdata;
    end

    // Transmit empty flag; a core take beats a host write
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_empty <= 1'b1;
        else if (tx_take)
            tx_empty <= 1'b1;
        else if (host_wr_data)
            tx_empty <= 1'b0;
    end

    AST_RX_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_load |=> rx_full); // R5
    AST_RX_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_data && !rx_load) |=> !rx_full); // R5
    AST_TX_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_take |=> tx_empty); // R6
    AST_TX_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_data && !tx_take) |=> !tx_empty); // R6

endmodule

// File: rtl/hpi_cmd.sv
// Module: host command register.
// Stores a pending bit and a command vector. Host writes are accepted only
// while no command is pending; the core accept strobe clears the pending bit.
module hpi_cmd #(
    parameter int VEC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cmd,
    input  logic             wr_pend,
    input  logic [VEC_W-1:0] wr_vec,
    input  logic             accept,
    output logic             pend,
    output logic [VEC_W-1:0] vec
);

    // Pending bit and vector; guarded against overwrite while pending
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
            vec  <= '0;
        end else if (pend) begin
            if (accept)
                pend <= 1'b0;
        end else if (wr_cmd) begin
            pend <= wr_pend;
            vec  <= wr_vec;
        end
    end

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !accept) |=> (pend && $stable(vec))); // R8
    AST_CMD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && accept) |=> !pend); // R8

endmodule

// File: rtl/hpi_ctrl.sv
// Module: control and vector registers plus the request combiner.
// The request is formed only in mode 00 from the masked flags.
// Assumes the vector reset value fits DATA_W.
module hpi_ctrl
    import hpi_pkg::*;
#(
    parameter int          DATA_W  = 8,
    parameter logic [7:0]  VEC_RST = 8'h0F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_vec,
    input  logic [CTRL_W-1:0] ctrl_din,
    input  logic [DATA_W-1:0] vec_din,
    input  logic              rx_full,
    input  logic              tx_empty,
    output hpi_ctrl_t         ctrl,
    output logic [DATA_W-1:0] vec,
    output logic              dma,
    output logic              irq
);

    // Control register holding masks and mode
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl <= '0;
        else if (wr_ctrl)
            ctrl <= hpi_ctrl_t'(ctrl_din);
    end

    // Vector register presented on acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)
            vec <= DATA_W'(VEC_RST);
        else if (wr_vec)
            vec <= vec_din;
    end

    // Mode decode and masked request combination
    always_comb begin
        dma = |ctrl.mode;
        irq = !dma && ((ctrl.tx_en && tx_empty) || (ctrl.rx_en && rx_full));
    end

endmodule

// File: rtl/hpi_bus.sv
// Module: host read path.
// Registers the addressed register one cycle after the read strobe and
// overrides it with the vector while the vector condition holds.
module hpi_bus
    import hpi_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int N_REG  = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd,
    input  logic [HPI_ADDR_W-1:0] addr,
    input  logic [N_REG*DATA_W-1:0] regs_flat,
    input  logic                  vec_drive,
    input  logic [DATA_W-1:0]     vec,
    output logic [DATA_W-1:0]     rdata,
    output logic                  rdata_oe
);

    localparam int N_ADDR = 1 << HPI_ADDR_W;

    logic [DATA_W-1:0] reg_arr [N_ADDR];
    logic [DATA_W-1:0] sel;
    logic [DATA_W-1:0] rd_data_q;
    logic              rd_q;

    // Unpack readable registers; unmapped addresses read zero
    for (genvar g = 0; g < N_ADDR; g++) begin : g_map
        if (g < N_REG) begin : g_real
            assign reg_arr[g] = regs_flat[g*DATA_W +: DATA_W];
        end else begin : g_zero
            assign reg_arr[g] = '0;
        end
    end

    // Address mux
    always_comb sel = reg_arr[addr];

    // Register read data one cycle after the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q      <= 1'b0;
            rd_data_q <= '0;
        end else begin
            rd_q <= rd;
            if (rd)
                rd_data_q <= sel;
        end
    end

    // Bus output: vector has priority over read data
    always_comb begin
        rdata_oe = vec_drive || rd_q;
        rdata    = vec_drive ? vec : rd_data_q;
    end

endmodule

// File: rtl/hpi_irq_top.sv
// Module: host-port request and vector logic, top level.
// Decodes host accesses, assembles the status byte and drives the
// open-drain request line and the host bus. Assumes DATA_W >= 8.
module hpi_irq_top
    import hpi_pkg::*;
#(
    parameter int         DATA_W  = 8,
    parameter int         VEC_W   = 5,
    parameter logic [7:0] VEC_RST = 8'h0F
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [HPI_ADDR_W-1:0] host_addr,
    input  logic                  host_rd,
    input  logic                  host_wr,
    input  logic [DATA_W-1:0]     host_wdata,
    input  logic                  host_ack,
    output logic [DATA_W-1:0]     host_rdata,
    output logic                  host_rdata_oe,
    output logic                  irq_o,
    output logic                  irq_oe,
    input  logic                  core_rx_load,
    input  logic [DATA_W-1:0]     core_rx_data,
    input  logic                  core_tx_take,
    output logic [DATA_W-1:0]     core_tx_data,
    input  logic                  core_cmd_accept,
    output logic                  core_cmd_pend,
    output logic [VEC_W-1:0]      core_cmd_vec
);

    localparam int N_REG = 5;
    localparam int CMD_PAD = DATA_W - 1 - VEC_W;

    logic              rd_data, wr_data, wr_ctrl, wr_vec, wr_cmd;
    logic              rx_full, tx_empty, dma, irq, vec_drive;
    logic [DATA_W-1:0] rx_q, vec_q;
    logic [DATA_W-1:0] ctrl_byte, cmd_byte, stat_byte;
    hpi_ctrl_t         ctrl;
    logic [N_REG*DATA_W-1:0] regs_flat;

    // Host access decode
    always_comb begin
        rd_data = host_rd && (host_addr == ADR_DATA);
        wr_data = host_wr && (host_addr == ADR_DATA);
        wr_ctrl = host_wr && (host_addr == ADR_CTRL);
        wr_vec  = host_wr && (host_addr == ADR_VEC);
        wr_cmd  = host_wr && (host_addr == ADR_CMD);
    end

    hpi_flags #(.DATA_W(DATA_W)) i_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_rd_data (rd_data),
        .host_wr_data (wr_data),
        .wdata        (host_wdata),
        .rx_load      (core_rx_load),
        .rx_din       (core_rx_data),
        .tx_take      (core_tx_take),
        .rx_full      (rx_full),
        .tx_empty     (tx_empty),
        .rx_q         (rx_q),
        .tx_q         (core_tx_data)
    );

    hpi_cmd #(.VEC_W(VEC_W)) i_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_cmd  (wr_cmd),
        .wr_pend (host_wdata[DATA_W-1]),
        .wr_vec  (host_wdata[VEC_W-1:0]),
        .accept  (core_cmd_accept),
        .pend    (core_cmd_pend),
        .vec     (core_cmd_vec)
    );

    hpi_ctrl #(.DATA_W(DATA_W), .VEC_RST(VEC_RST)) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctrl  (wr_ctrl),
        .wr_vec   (wr_vec),
        .ctrl_din (host_wdata[CTRL_W-1:0]),
        .vec_din  (host_wdata),
        .rx_full  (rx_full),
        .tx_empty (tx_empty),
        .ctrl     (ctrl),
        .vec      (vec_q),
        .dma      (dma),
        .irq      (irq)
    );

    // Readable register images
    always_comb begin
        ctrl_byte = {{(DATA_W-CTRL_W){1'b0}}, ctrl};
        cmd_byte  = {core_cmd_pend, {CMD_PAD{1'b0}}, core_cmd_vec};
        stat_byte = '0;
        stat_byte[ST_REQ] = irq;
        stat_byte[ST_DMA] = dma;
        stat_byte[ST_TXE] = tx_empty;
        stat_byte[ST_RXF] = rx_full;
        regs_flat = {rx_q, vec_q, stat_byte, cmd_byte, ctrl_byte};
    end

    // Open-drain request line and vector condition
    always_comb begin
        irq_o     = 1'b0;
        irq_oe    = irq;
        vec_drive = irq && host_ack;
    end

    hpi_bus #(.DATA_W(DATA_W), .N_REG(N_REG)) i_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd        (host_rd),
        .addr      (host_addr),
        .regs_flat (regs_flat),
        .vec_drive (vec_drive),
        .vec       (vec_q),
        .rdata     (host_rdata),
        .rdata_oe  (host_rdata_oe)
    );

    AST_VEC_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_oe && host_ack) |-> (host_rdata_oe && host_rdata == vec_q)); // R7
    AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd |=> host_rdata_oe); // R10
    AST_DMA_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.mode != 2'b00) |-> !irq_oe); // R9
    AST_LINE_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o); // R11

endmodule

// File: tb/test_hpi_irq_top.sv
module test_hpi_irq_top;
    import hpi_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] host_addr = '0;
    logic       host_rd = 1'b0, host_wr = 1'b0, host_ack = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       host_rdata_oe, irq_o, irq_oe;
    logic       core_rx_load = 1'b0, core_tx_take = 1'b0, core_cmd_accept = 1'b0;
    logic [7:0] core_rx_data = '0;
    logic [7:0] core_tx_data;
    logic       core_cmd_pend;
    logic [4:0] core_cmd_vec;
    wire        irq_line = irq_oe ? irq_o : 1'b1;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;   // 125 MHz

    hpi_irq_top i_hpi_irq_top (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_ack(host_ack),
        .host_rdata(host_rdata), .host_rdata_oe(host_rdata_oe),
        .irq_o(irq_o), .irq_oe(irq_oe), .core_rx_load(core_rx_load),
        .core_rx_data(core_rx_data), .core_tx_take(core_tx_take),
        .core_tx_data(core_tx_data), .core_cmd_accept(core_cmd_accept),
        .core_cmd_pend(core_cmd_pend), .core_cmd_vec(core_cmd_vec)
    );

    task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected read data when the bus is driven without acknowledge
    always @(negedge clk) begin
        if (rst_n && host_rdata_oe && !host_ack) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected bus drive", host_rdata, 8'h00);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string      t = tag_q.pop_front();
                check(host_rdata == e, t, host_rdata, e);
            end
        end
    end

    // Driver: host read, pushes expected value to the scoreboard
    task automatic host_read(input logic [2:0] a, input logic [7:0] e, input string t);
        @(posedge clk); #1;
        host_rd = 1'b1; host_addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(posedge clk); #1;
        host_rd = 1'b0;
    endtask

    task automatic host_write(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic rx_load(input logic [7:0] d);
        @(posedge clk); #1;
        core_rx_load = 1'b1; core_rx_data = d;
        @(posedge clk); #1;
        core_rx_load = 1'b0;
    endtask

    task automatic tx_take();
        @(posedge clk); #1;
        core_tx_take = 1'b1;
        @(posedge clk); #1;
        core_tx_take = 1'b0;
    endtask

    task automatic cmd_accept();
        @(posedge clk); #1;
        core_cmd_accept = 1'b1;
        @(posedge clk); #1;
        core_cmd_accept = 1'b0;
    endtask

    task automatic line_check(input logic exp, input string t);
        @(negedge clk);
        check(irq_line == exp, t, {7'b0, irq_line}, {7'b0, exp});
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog expired", 8'h00, 8'h01);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(irq_line == 1'b1, "R1 line released", {7'b0, irq_line}, 8'h01);
        check(host_rdata_oe == 1'b0, "R1 bus idle", {7'b0, host_rdata_oe}, 8'h00);
        check(irq_o == 1'b0, "R11 data low", {7'b0, irq_o}, 8'h00);
        host_read(ADR_CTRL, 8'h00, "R1 ctrl reset");
        host_read(ADR_VEC,  8'h0F, "R1 vector reset");
        host_read(ADR_STAT, 8'h02, "R1 status reset");
        host_read(3'd6,     8'h00, "R2 unmapped");

        // R3 transmit request
        host_write(ADR_CTRL, 8'hF1);
        line_check(1'b0, "R3 tx request");
        host_read(ADR_CTRL, 8'h01, "R2 ctrl readback");
        host_read(ADR_STAT, 8'h82, "R9 status mirror");
        host_write(ADR_STAT, 8'hFF);
        host_read(ADR_STAT, 8'h82, "R2 status write ignored");

        // R4/R6 service and refill
        host_write(ADR_DATA, 8'hA5);
        line_check(1'b1, "R4 released by data write");
        tx_take();
        @(negedge clk);
        check(core_tx_data == 8'hA5, "R6 tx byte", core_tx_data, 8'hA5);
        line_check(1'b0, "R6 take sets empty");
        host_write(ADR_CTRL, 8'h00);
        line_check(1'b1, "R4 released by mask");

        // R5 receive request
        host_write(ADR_CTRL, 8'h02);
        rx_load(8'h3C);
        line_check(1'b0, "R3 rx request");
        host_read(ADR_STAT, 8'h83, "R5 rx full status");
        host_read(ADR_DATA, 8'h3C, "R5 rx data");
        line_check(1'b1, "R4 released by data read");
        host_read(ADR_STAT, 8'h02, "R5 rx cleared");

        // R5 load and read in the same cycle
        rx_load(8'h11);
        @(posedge clk); #1;
        host_rd = 1'b1; host_addr = ADR_DATA; core_rx_load = 1'b1; core_rx_data = 8'h22;
        exp_q.push_back(8'h11); tag_q.push_back("R5 collision old byte");
        @(posedge clk); #1;
        host_rd = 1'b0; core_rx_load = 1'b0;
        host_read(ADR_STAT, 8'h83, "R5 set wins");
        host_read(ADR_DATA, 8'h22, "R5 new byte");

        // R6 write and take in the same cycle
        @(posedge clk); #1;
        host_wr = 1'b1; host_addr = ADR_DATA; host_wdata = 8'h77; core_tx_take = 1'b1;
        @(posedge clk); #1;
        host_wr = 1'b0; core_tx_take = 1'b0;
        host_read(ADR_STAT, 8'h02, "R6 set wins");

        // R7 vector on acknowledge
        host_write(ADR_VEC, 8'h5A);
        host_read(ADR_VEC, 8'h5A, "R2 vector readback");
        host_write(ADR_CTRL, 8'h01);
        @(posedge clk); #1;
        host_ack = 1'b1; host_rd = 1'b1; host_addr = ADR_CTRL;
        @(negedge clk);
        check(host_rdata_oe && host_rdata == 8'h5A, "R7 vector drive", host_rdata, 8'h5A);
        @(posedge clk); #1;
        host_rd = 1'b0;
        @(negedge clk);
        check(host_rdata_oe && host_rdata == 8'h5A, "R7 vector over read", host_rdata, 8'h5A);
        @(posedge clk); #1;
        host_ack = 1'b0;
        host_write(ADR_CTRL, 8'h00);
        @(posedge clk); #1;
        host_ack = 1'b1;
        @(negedge clk);
        check(host_rdata_oe == 1'b0, "R7 ack without request", {7'b0, host_rdata_oe}, 8'h00);
        @(posedge clk); #1;
        host_ack = 1'b0;

        // R9 DMA modes
        host_write(ADR_CTRL, 8'h05);
        line_check(1'b1, "R9 dma silent");
        host_read(ADR_STAT, 8'h42, "R9 dma status");
        host_write(ADR_CTRL, 8'h0D);
        line_check(1'b1, "R9 dma mode 3 silent");
        host_read(ADR_STAT, 8'h42, "R9 dma mode 3 status");
        host_write(ADR_CTRL, 8'h01);
        line_check(1'b0, "R3 back to non-dma");
        host_write(ADR_CTRL, 8'h00);

        // R8 command register
        host_write(ADR_CMD, 8'h85);
        @(negedge clk);
        check(core_cmd_pend && core_cmd_vec == 5'd5, "R8 pending",
              {2'b0, core_cmd_pend, core_cmd_vec}, 8'h25);
        host_read(ADR_CMD, 8'h85, "R8 pending read");
        host_write(ADR_CMD, 8'h83);
        host_read(ADR_CMD, 8'h85, "R8 write ignored while pending");
        cmd_accept();
        host_read(ADR_CMD, 8'h05, "R8 accepted");
        host_write(ADR_CMD, 8'h07);
        host_read(ADR_CMD, 8'h07, "R8 no-command write");

        // R10 drain
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(exp_q.size() == 0 && !host_rdata_oe, "R10 scoreboard drained",
              8'(exp_q.size()), 8'h00);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule